// File: doc/BRIEF.md
# Register Reservation Scoreboard

This block records which architectural registers are still waiting for a result from an instruction in flight. The decode stage asks it, in the same cycle, whether either of up to two source registers is waiting. If one is, decode holds the instruction. When decode issues an instruction that writes a register, it reserves that register here. The block returns a destination tag that travels down the pipe with the instruction. When writeback commits the result, it hands the tag back and the register is freed.

The register index space has two parts. It starts with the general-purpose registers and continues with the vector registers. An index at or above the general-purpose count selects a vector register, and each bank keeps its own reservation bits. Register zero always reads as zero, so it is never reserved. An index beyond both banks is an error. A flush clears every reservation at once. A sticky error flag records out-of-range indices and releases of registers that were not reserved.

Top module: `resv_scoreboard`

## Requirements
- R1: `srcAStall` (and likewise `srcBStall`) is 1 in the same cycle when its valid input is 1, its index is in range, and that register is reserved. Otherwise it is 0. The stall reflects only the reservations held at the start of the cycle.
- R2: A reserve request for index 0 is ignored. `dstTag` reads as all ones (-1), no reservation is made, and no error is raised.
- R3: Any number of registers can be reserved at once. An accepted reservation becomes visible to the checks from the next cycle, and not in the cycle of the request.
- R4: `dstTag` equals the requested index, as a positive number with a zero sign bit, when the reservation is accepted. In every other case it is all ones (-1).
- R5: A release with `wbValid`=1 and a tag greater than 0 frees that register from the next cycle. A tag of 0 or a negative tag is ignored and raises no error.
- R6: Indices 0 to G-1 select general register k. Indices G to G+V-1 select vector register k-G. Reserving vector register k-G does not reserve general register k-G, and the reverse also holds (G=16, V=8 by default).
- R7: A valid index at or above G+V on any port sets `errFlag` from the next cycle. Such an index never stalls, never reserves (tag -1) and never releases.
- R8: `flush` clears all reservations from the next cycle. A reserve or release in the flush cycle is ignored, the tag reads -1, and no error is raised.
- R9: If a release and a reserve name the same register in the same cycle, the register stays reserved.
- R10: Releasing an in-range register that is not reserved sets `errFlag` from the next cycle.
- R11: `errFlag` stays at 1 until reset. Reset clears it and all reservations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all reservations |
| srcAValid | input | 1 | Source A check request |
| srcAIdx | input | IDX_W | Source A register index |
| srcBValid | input | 1 | Source B check request |
| srcBIdx | input | IDX_W | Source B register index |
| srcAStall | output | 1 | Source A is reserved |
| srcBStall | output | 1 | Source B is reserved |
| dstValid | input | 1 | Reserve request |
| dstIdx | input | IDX_W | Register to reserve |
| dstTag | output | IDX_W+1 | Signed tag that travels with the instruction, -1 when nothing was reserved |
| wbValid | input | 1 | Release request |
| wbTag | input | IDX_W+1 | Signed tag of the register to release |
| errFlag | output | 1 | Sticky error |

## Verification
The bench reserves a register and checks it in the same cycle. A design that forwarded new reservations would stall a check that should pass here. It reserves general register k and vector register k and checks them against each other. A design that folded the two banks together would stall on the wrong register. It collides a reserve with a release of the same register, and with a flush. Letting the release win would drop a real hazard. Letting the reserve survive a flush would leave a register locked forever. It also releases tags 0 and -1, and registers that were never reserved. A design that treated these wrongly would either free register zero or keep a genuine error hidden.

// File: rtl/resv_pkg.sv
package resv_pkg;
  // Strobes handed from the control to the reservation bit banks.
  typedef struct packed {
    logic setEn;   // reserve the register at setLoc
    logic setVec;  // setLoc names a vector register
    logic clrEn;   // free the register at relLoc
    logic clrVec;  // relLoc names a vector register
    logic wipe;    // drop every reservation
  } resvStrobes_t;
endpackage

// File: rtl/resv_bits.sv
module resv_bits
  import resv_pkg::*;
#(
  parameter int GPR_COUNT = 16,
  parameter int VEC_COUNT = 8,
  parameter int IDX_W     = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  resvStrobes_t     strobe,
  input  logic [IDX_W-1:0] setLoc,
  input  logic [IDX_W-1:0] relLoc,
  input  logic             aVec,
  input  logic [IDX_W-1:0] aLoc,
  input  logic             bVec,
  input  logic [IDX_W-1:0] bLoc,
  output logic             busyA,
  output logic             busyB,
  output logic             busyRel
);
  logic [GPR_COUNT-1:0] gprBusy, gprSet, gprClr;
  logic [VEC_COUNT-1:0] vecBusy, vecSet, vecClr;

  function automatic logic pickBit(input logic isVec, input logic [IDX_W-1:0] loc,
                                   input logic [GPR_COUNT-1:0] g,
                                   input logic [VEC_COUNT-1:0] v);
    logic r;
    r = 1'b0;
    for (int i = 0; i < GPR_COUNT; i++)
      if (!isVec && loc == IDX_W'(i)) r = r | g[i];
    for (int i = 0; i < VEC_COUNT; i++)
      if (isVec && loc == IDX_W'(i)) r = r | v[i];
    return r;
  endfunction

  for (genvar g = 0; g < GPR_COUNT; g++) begin : gen_gpr
    assign gprSet[g] = strobe.setEn && !strobe.setVec && (setLoc == IDX_W'(g));
    assign gprClr[g] = strobe.clrEn && !strobe.clrVec && (relLoc == IDX_W'(g));

    assert_gpr_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      gprSet[g] && !strobe.wipe |=> gprBusy[g]);
    assert_gpr_release_R5: assert property (@(posedge clk) disable iff (!rstN)
      gprClr[g] && !gprSet[g] && !strobe.wipe |=> !gprBusy[g]);
  end

  for (genvar v = 0; v < VEC_COUNT; v++) begin : gen_vec
    assign vecSet[v] = strobe.setEn && strobe.setVec && (setLoc == IDX_W'(v));
    assign vecClr[v] = strobe.clrEn && strobe.clrVec && (relLoc == IDX_W'(v));

    assert_vec_set_R3: assert property (@(posedge clk) disable iff (!rstN)
      vecSet[v] && !strobe.wipe |=> vecBusy[v]);
    assert_vec_release_R5: assert property (@(posedge clk) disable iff (!rstN)
      vecClr[v] && !vecSet[v] && !strobe.wipe |=> !vecBusy[v]);
  end

  // Reserve wins over a release of the same bit; wipe beats both.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gprBusy <= '0;
      vecBusy <= '0;
    end else if (strobe.wipe) begin
      gprBusy <= '0;
      vecBusy <= '0;
    end else begin
      gprBusy <= (gprBusy & ~gprClr) | gprSet;
      vecBusy <= (vecBusy & ~vecClr) | vecSet;
    end
  end

  always_comb begin
    busyA   = pickBit(aVec, aLoc, gprBusy, vecBusy);
    busyB   = pickBit(bVec, bLoc, gprBusy, vecBusy);
    busyRel = pickBit(strobe.clrVec, relLoc, gprBusy, vecBusy);
  end

  assert_zero_never_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    !gprBusy[0]);
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipe |=> (gprBusy == '0 && vecBusy == '0));
endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter int GPR_COUNT = 16,
  parameter int VEC_COUNT = 8,
  parameter int IDX_W     = 5,
  parameter int TAG_W     = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic                    srcAValid,
  input  logic [IDX_W-1:0]        srcAIdx,
  input  logic                    srcBValid,
  input  logic [IDX_W-1:0]        srcBIdx,
  input  logic                    dstValid,
  input  logic [IDX_W-1:0]        dstIdx,
  input  logic                    wbValid,
  input  logic signed [TAG_W-1:0] wbTag,
  input  logic                    busyA,
  input  logic                    busyB,
  input  logic                    busyRel,
  output resvStrobes_t            strobe,
  output logic [IDX_W-1:0]        setLoc,
  output logic [IDX_W-1:0]        relLoc,
  output logic                    aVec,
  output logic [IDX_W-1:0]        aLoc,
  output logic                    bVec,
  output logic [IDX_W-1:0]        bLoc,
  output logic                    srcAStall,
  output logic                    srcBStall,
  output logic [TAG_W-1:0]        dstTag,
  output logic                    errFlag
);
  localparam int TOTAL = GPR_COUNT + VEC_COUNT;

  function automatic logic inSpace(input logic [IDX_W-1:0] i);
    return int'(i) < TOTAL;
  endfunction
  function automatic logic isVecIdx(input logic [IDX_W-1:0] i);
    return int'(i) >= GPR_COUNT;
  endfunction
  function automatic logic [IDX_W-1:0] bankLoc(input logic [IDX_W-1:0] i);
    return isVecIdx(i) ? i - IDX_W'(GPR_COUNT) : i;
  endfunction

  logic [IDX_W-1:0] relIdx;
  logic relPos, relInSpace, dstAccept, rangeErr, missErr;

  always_comb begin
    relIdx     = wbTag[IDX_W-1:0];
    relPos     = !wbTag[TAG_W-1] && (wbTag != '0);
    relInSpace = inSpace(relIdx);

    aVec = isVecIdx(srcAIdx);
    aLoc = bankLoc(srcAIdx);
    bVec = isVecIdx(srcBIdx);
    bLoc = bankLoc(srcBIdx);

    srcAStall = srcAValid && inSpace(srcAIdx) && busyA;
    srcBStall = srcBValid && inSpace(srcBIdx) && busyB;

    dstAccept = dstValid && inSpace(dstIdx) && (dstIdx != '0) && !flush;
    dstTag    = dstAccept ? {1'b0, dstIdx} : '1;

    setLoc        = bankLoc(dstIdx);
    relLoc        = bankLoc(relIdx);
    strobe.setEn  = dstAccept;
    strobe.setVec = isVecIdx(dstIdx);
    strobe.clrEn  = wbValid && relPos && relInSpace && !flush;
    strobe.clrVec = isVecIdx(relIdx);
    strobe.wipe   = flush;

    rangeErr = (srcAValid && !inSpace(srcAIdx)) ||
               (srcBValid && !inSpace(srcBIdx)) ||
               (dstValid && !inSpace(dstIdx)) ||
               (wbValid && relPos && !relInSpace);
    missErr  = wbValid && relPos && relInSpace && !busyRel && !flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else if (rangeErr || missErr) errFlag <= 1'b1;
  end

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  assert_zero_no_tag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dstValid && dstIdx == '0) |-> (dstTag == '1 && !strobe.setEn));
  assert_oor_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (srcAValid && int'(srcAIdx) >= TOTAL) |=> errFlag);
  assert_oor_no_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    (int'(srcAIdx) >= TOTAL) |-> !srcAStall);
  assert_flush_no_tag_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> (dstTag == '1 && !strobe.clrEn));
  assert_miss_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && relPos && relInSpace && !busyRel && !flush) |=> errFlag);
endmodule

// File: rtl/resv_scoreboard.sv
module resv_scoreboard #(
  parameter int GPR_COUNT = 16,
  parameter int VEC_COUNT = 8,
  parameter int IDX_W     = $clog2(GPR_COUNT + VEC_COUNT),
  parameter int TAG_W     = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic                    srcAValid,
  input  logic [IDX_W-1:0]        srcAIdx,
  input  logic                    srcBValid,
  input  logic [IDX_W-1:0]        srcBIdx,
  output logic                    srcAStall,
  output logic                    srcBStall,
  input  logic                    dstValid,
  input  logic [IDX_W-1:0]        dstIdx,
  output logic [TAG_W-1:0]        dstTag,
  input  logic                    wbValid,
  input  logic signed [TAG_W-1:0] wbTag,
  output logic                    errFlag
);
  resv_pkg::resvStrobes_t strobe;
  logic [IDX_W-1:0] setLoc, relLoc, aLoc, bLoc;
  logic aVec, bVec, busyA, busyB, busyRel;

  resv_ctrl #(.GPR_COUNT(GPR_COUNT), .VEC_COUNT(VEC_COUNT), .IDX_W(IDX_W), .TAG_W(TAG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .flush(flush),
    .srcAValid(srcAValid), .srcAIdx(srcAIdx), .srcBValid(srcBValid), .srcBIdx(srcBIdx),
    .dstValid(dstValid), .dstIdx(dstIdx), .wbValid(wbValid), .wbTag(wbTag),
    .busyA(busyA), .busyB(busyB), .busyRel(busyRel),
    .strobe(strobe), .setLoc(setLoc), .relLoc(relLoc),
    .aVec(aVec), .aLoc(aLoc), .bVec(bVec), .bLoc(bLoc),
    .srcAStall(srcAStall), .srcBStall(srcBStall), .dstTag(dstTag), .errFlag(errFlag)
  );

  resv_bits #(.GPR_COUNT(GPR_COUNT), .VEC_COUNT(VEC_COUNT), .IDX_W(IDX_W)) bits_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setLoc(setLoc), .relLoc(relLoc),
    .aVec(aVec), .aLoc(aLoc), .bVec(bVec), .bLoc(bLoc),
    .busyA(busyA), .busyB(busyB), .busyRel(busyRel)
  );
endmodule

// File: tb/resv_scoreboard_tb_top.sv
module resv_scoreboard_tb_top;
  localparam int IW = 5;
  localparam int TW = 6;

  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0;
  logic srcAValid = 1'b0, srcBValid = 1'b0, dstValid = 1'b0, wbValid = 1'b0;
  logic [IW-1:0] srcAIdx = '0, srcBIdx = '0, dstIdx = '0;
  logic signed [TW-1:0] wbTag = '0;
  logic srcAStall, srcBStall, errFlag;
  logic [TW-1:0] dstTag;
  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  resv_scoreboard dut_i (
    .clk(clk), .rstN(rstN), .flush(flush),
    .srcAValid(srcAValid), .srcAIdx(srcAIdx), .srcBValid(srcBValid), .srcBIdx(srcBIdx),
    .srcAStall(srcAStall), .srcBStall(srcBStall),
    .dstValid(dstValid), .dstIdx(dstIdx), .dstTag(dstTag),
    .wbValid(wbValid), .wbTag(wbTag), .errFlag(errFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; srcAValid = 0; srcBValid = 0; dstValid = 0; wbValid = 0;
  endtask

  // Inputs are set at a falling edge; the next rising edge lands in nextCycle.
  task automatic nextCycle();
    @(negedge clk);
    idle();
  endtask

  task automatic doReset();
    @(negedge clk);
    idle();
    rstN = 0;
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic reserve(input int idx);
    dstValid = 1; dstIdx = IW'(idx);
    nextCycle();
  endtask

  function automatic int tagVal();
    return int'($signed(dstTag));
  endfunction

  // Returns stall of register idx through port A (0) or B (1), no clock.
  task automatic probe(input int idx, input bit useB, output int st);
    if (useB) begin srcBValid = 1; srcBIdx = IW'(idx); end
    else begin srcAValid = 1; srcAIdx = IW'(idx); end
    #1;
    st = useB ? int'(srcBStall) : int'(srcAStall);
    srcAValid = 0; srcBValid = 0;
  endtask

  task automatic t_reset();
    int st, any;
    doReset();
    any = 0;
    for (int i = 0; i < 24; i++) begin probe(i, 0, st); any += st; end
    chk("R11 reset no reservations", any, 0);
    chk("R11 reset errFlag", int'(errFlag), 0);
    #1 chk("R4 idle tag", tagVal(), -1);
  endtask

  task automatic t_multi();
    int st;
    doReset();
    for (int i = 1; i <= 5; i++) begin
      dstValid = 1; dstIdx = IW'(i); #1;
      chk("R4 tag equals index", tagVal(), i);
      nextCycle();
    end
    dstValid = 1; dstIdx = 6; srcAValid = 1; srcAIdx = 6; #1;
    chk("R3 same-cycle reserve not visible", int'(srcAStall), 0);
    nextCycle();
    probe(6, 0, st); chk("R3 reserve visible next cycle", st, 1);
    probe(1, 0, st); chk("R1 reg1 stalls with 1..6 held", st, 1);
    probe(3, 1, st); chk("R1 port B stalls", st, 1);
    probe(7, 0, st); chk("R1 free reg ok", st, 0);
    srcAValid = 0; srcAIdx = 2; #1;
    chk("R1 invalid check no stall", int'(srcAStall), 0);
    chk("R3 no error", int'(errFlag), 0);
  endtask

  task automatic t_zero();
    int st;
    doReset();
    dstValid = 1; dstIdx = 0; #1;
    chk("R2 zero tag", tagVal(), -1);
    nextCycle();
    probe(0, 0, st); chk("R2 zero not reserved", st, 0);
    chk("R2 zero no error", int'(errFlag), 0);
  endtask

  task automatic t_banks();
    int st;
    doReset();
    reserve(17);
    probe(17, 0, st); chk("R6 vector 1 held", st, 1);
    probe(1, 1, st);  chk("R6 general 1 free", st, 0);
    reserve(2);
    probe(18, 0, st); chk("R6 vector 2 free", st, 0);
    dstValid = 1; dstIdx = 23; #1;
    chk("R4 top vector tag", tagVal(), 23);
    nextCycle();
    probe(23, 1, st); chk("R6 top vector held", st, 1);
  endtask

  task automatic t_release();
    int st;
    doReset();
    reserve(17); reserve(9);
    wbValid = 1; wbTag = 17; srcAValid = 1; srcAIdx = 17; #1;
    chk("R5 release same cycle still stalls", int'(srcAStall), 1);
    nextCycle();
    probe(17, 0, st); chk("R5 released next cycle", st, 0);
    wbValid = 1; wbTag = 0; nextCycle();
    wbValid = 1; wbTag = -1; nextCycle();
    probe(9, 0, st); chk("R5 tag 0/-1 ignored", st, 1);
    chk("R5 tag 0/-1 no error", int'(errFlag), 0);
  endtask

  task automatic t_collide();
    int st;
    doReset();
    reserve(4);
    dstValid = 1; dstIdx = 4; wbValid = 1; wbTag = 4;
    nextCycle();
    probe(4, 0, st); chk("R9 reserve wins", st, 1);
    chk("R9 no error", int'(errFlag), 0);
  endtask

  task automatic t_flush();
    int st, any;
    doReset();
    reserve(3); reserve(20); reserve(8);
    flush = 1; dstValid = 1; dstIdx = 9; wbValid = 1; wbTag = 5; #1;
    chk("R8 flush-cycle tag", tagVal(), -1);
    nextCycle();
    any = 0;
    for (int i = 0; i < 24; i++) begin probe(i, 0, st); any += st; end
    chk("R8 flush cleared all", any, 0);
    chk("R8 flush release no error", int'(errFlag), 0);
  endtask

  task automatic t_range();
    int st;
    doReset();
    srcAValid = 1; srcAIdx = 24; #1;
    chk("R7 out-of-range no stall", int'(srcAStall), 0);
    nextCycle();
    chk("R7 check error", int'(errFlag), 1);
    nextCycle(); nextCycle();
    chk("R11 error sticky", int'(errFlag), 1);
    doReset();
    chk("R11 reset clears error", int'(errFlag), 0);
    dstValid = 1; dstIdx = 30; #1;
    chk("R7 reserve out-of-range tag", tagVal(), -1);
    nextCycle();
    chk("R7 reserve error", int'(errFlag), 1);
    doReset();
    wbValid = 1; wbTag = 25; nextCycle();
    chk("R7 release error", int'(errFlag), 1);
  endtask

  task automatic t_miss();
    doReset();
    wbValid = 1; wbTag = 3; nextCycle();
    chk("R10 release unreserved error", int'(errFlag), 1);
  endtask

  initial begin
    t_reset();
    t_multi();
    t_zero();
    t_banks();
    t_release();
    t_collide();
    t_flush();
    t_range();
    t_miss();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule